// File: doc/BRIEF.md
# Configurable Ready/Valid Queue

This block is a first-in first-out buffer with a valid/ready handshake on both sides. An item moves in on a clock edge where `inVal` and `inRdy` are both high. It moves out on an edge where `outVal` and `outRdy` are both high. The storage is a register array. At a depth of one it is a single register, and no spare entry is added.

Two build-time options shape the timing:

- **PIPE** lets a full queue take a new item in the same cycle that its oldest item leaves. The input ready then also depends on the output ready.
- **FLOW** adds a bypass for the empty queue. The incoming item appears at the output in the same cycle, without going through storage. The bypass is selected by explicit empty detection and never depends on the storage reading back a write.

At depth one, PIPE without FLOW gives a plain registered pipeline stage. FLOW without PIPE gives a stage whose input ready does not depend on the output ready. A count output reports how many items are held.

Top module: `rvq_queue`

## Requirements
- R1: Items leave in the order they entered, each exactly once, under any pattern of `inVal` and `outRdy`. While an item is held and not taken, `outVal` stays high and `outData` stays unchanged.
- R2: With PIPE off, `inRdy` is high exactly when `count` is below DEPTH.
- R3: With PIPE on, `inRdy` is high when `count` is below DEPTH or `outRdy` is high. A full queue therefore accepts and releases an item on the same edge.
- R4: `outVal` is high when `count` is nonzero, or when FLOW is on and `inVal` is high.
- R5: With FLOW on and `count` zero, `outData` equals `inData` in the same cycle. If that item is taken on the same edge, `count` stays zero.
- R6: `count` gives the number of stored items. It rises by one on an accept without a release, falls by one on a release without an accept, and never exceeds DEPTH.
- R7: The synchronous active-high `rst` empties the queue. After reset, `count` is 0, `inRdy` is high, and `outVal` is low while `inVal` is low.
- R8: DEPTH of 1 is supported with a single holding register, in both the PIPE-only and FLOW-only variants.
- R9: With FLOW off, an empty queue keeps `outVal` low even when `inVal` is high. An accepted item appears at the output from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| inVal | input | 1 | Enqueue side: item offered |
| inRdy | output | 1 | Enqueue side: queue can take the item |
| inData | input | DATA_W | Enqueue side payload |
| outVal | output | 1 | Dequeue side: item available |
| outRdy | input | 1 | Dequeue side: consumer takes the item |
| outData | output | DATA_W | Dequeue side payload |
| count | output | $clog2(DEPTH+1) | Number of stored items |

## Verification
The embedded properties check these rules on every cycle:

- the count steps by at most one in the right direction for each handshake combination;
- the count never passes the depth;
- ready is withheld when full without PIPE and granted when PIPE sees the output ready;
- an empty queue without FLOW never asserts valid;
- a held, untaken head keeps its data.

Properties alone cannot show payload order, the absence of lost or duplicated items, or the exact bypass data. The bench shows these by running four configurations in lockstep against an arithmetic queue model, under skewed and balanced traffic.

// File: rtl/rvq_pkg.sv
package rvq_pkg;

  // Strobes from control to datapath
  typedef struct packed {
    logic wrEn;      // store inData into the slot at wrIdx
    logic passThru;  // empty-queue bypass: output shows inData
  } rvqStrobe_t;

endpackage

// File: rtl/rvq_ctrl.sv
module rvq_ctrl
  import rvq_pkg::*;
#(
  parameter int DEPTH = 4,
  parameter bit PIPE  = 1'b0,
  parameter bit FLOW  = 1'b0,
  parameter int PTR_W = 2,
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inVal,
  output logic             inRdy,
  output logic             outVal,
  input  logic             outRdy,
  output rvqStrobe_t       strb,
  output logic [PTR_W-1:0] wrIdx,
  output logic [PTR_W-1:0] rdIdx,
  output logic [CNT_W-1:0] count
);

  logic [PTR_W-1:0] wrPtr, rdPtr;
  logic             fullQ;
  logic             isEmpty;
  logic             enq, deq, pushSt, popSt;

  function automatic logic [PTR_W-1:0] bumpPtr(input logic [PTR_W-1:0] p);
    if (32'(p) >= DEPTH - 1) return '0;
    return p + 1'b1;
  endfunction

  assign isEmpty = (wrPtr == rdPtr) && !fullQ;

  generate
    if (PIPE) begin : g_pipeRdy
      assign inRdy = !fullQ || outRdy;
    end else begin : g_plainRdy
      assign inRdy = !fullQ;
    end
  endgenerate

  assign outVal = !isEmpty || (FLOW && inVal);

  assign enq = inVal && inRdy;
  assign deq = outVal && outRdy;

  // With the bypass active, an item taken on the same edge never enters storage
  assign strb.passThru = FLOW && isEmpty;
  assign pushSt = enq && !(strb.passThru && deq);
  assign popSt  = deq && !strb.passThru;
  assign strb.wrEn = pushSt;
  assign wrIdx = wrPtr;
  assign rdIdx = rdPtr;

  always_ff @(posedge clk) begin
    if (rst) begin
      wrPtr <= '0;
      rdPtr <= '0;
      fullQ <= 1'b0;
    end else begin
      if (pushSt) wrPtr <= bumpPtr(wrPtr);
      if (popSt)  rdPtr <= bumpPtr(rdPtr);
      if (pushSt && !popSt && (bumpPtr(wrPtr) == rdPtr)) fullQ <= 1'b1;
      else if (popSt && !pushSt)                          fullQ <= 1'b0;
    end
  end

  always_comb begin
    if (fullQ)               count = CNT_W'(DEPTH);
    else if (wrPtr >= rdPtr) count = CNT_W'(wrPtr - rdPtr);
    else                     count = CNT_W'(DEPTH - 32'(rdPtr) + 32'(wrPtr));
  end

  // Embedded properties
  p_count_range_r6: assert property (@(posedge clk) disable iff (rst)
    32'(count) <= DEPTH);

  p_count_up_r6: assert property (@(posedge clk) disable iff (rst)
    (inVal && inRdy && !(outVal && outRdy)) |=> (32'(count) == 32'($past(count)) + 1));

  p_count_down_r6: assert property (@(posedge clk) disable iff (rst)
    (!(inVal && inRdy) && outVal && outRdy) |=> (32'(count) + 1 == 32'($past(count))));

  p_bypass_keeps_empty_r5: assert property (@(posedge clk) disable iff (rst)
    (FLOW && count == '0 && inVal && outRdy) |=> (count == '0));

  p_noflow_empty_r9: assert property (@(posedge clk) disable iff (rst)
    (!FLOW && count == '0) |-> !outVal);

  p_full_stall_r2: assert property (@(posedge clk) disable iff (rst)
    (!PIPE && 32'(count) == DEPTH) |-> !inRdy);

  p_pipe_accept_r3: assert property (@(posedge clk) disable iff (rst)
    (PIPE && outRdy) |-> inRdy);

endmodule

// File: rtl/rvq_store.sv
module rvq_store
  import rvq_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 4,
  parameter int PTR_W  = 2
) (
  input  logic              clk,
  input  rvqStrobe_t        strb,
  input  logic [PTR_W-1:0]  wrIdx,
  input  logic [PTR_W-1:0]  rdIdx,
  input  logic [DATA_W-1:0] inData,
  output logic [DATA_W-1:0] outData
);

  logic [DATA_W-1:0] headData;

  generate
    if (DEPTH == 1) begin : g_single
      // One holding register; pointers carry no information here
      logic [DATA_W-1:0] holdQ;
      logic              idxUnused;
      assign idxUnused = ^{wrIdx, rdIdx};
      always_ff @(posedge clk) begin
        if (strb.wrEn) holdQ <= inData;
      end
      assign headData = holdQ;
    end else begin : g_array
      logic [DATA_W-1:0] slotQ [DEPTH];
      always_ff @(posedge clk) begin
        if (strb.wrEn) slotQ[wrIdx] <= inData;
      end
      assign headData = slotQ[rdIdx];
    end
  endgenerate

  // The bypass is chosen by the control's empty detection, never by write-through
  assign outData = strb.passThru ? inData : headData;

endmodule

// File: rtl/rvq_queue.sv
module rvq_queue
  import rvq_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 4,
  parameter bit PIPE   = 1'b0,
  parameter bit FLOW   = 1'b0,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              inVal,
  output logic              inRdy,
  input  logic [DATA_W-1:0] inData,
  output logic              outVal,
  input  logic              outRdy,
  output logic [DATA_W-1:0] outData,
  output logic [CNT_W-1:0]  count
);

  rvqStrobe_t       strb;
  logic [PTR_W-1:0] wrIdx, rdIdx;

  rvq_ctrl #(
    .DEPTH(DEPTH), .PIPE(PIPE), .FLOW(FLOW), .PTR_W(PTR_W), .CNT_W(CNT_W)
  ) ctrl_i (
    .clk(clk), .rst(rst), .inVal(inVal), .inRdy(inRdy),
    .outVal(outVal), .outRdy(outRdy), .strb(strb),
    .wrIdx(wrIdx), .rdIdx(rdIdx), .count(count)
  );

  rvq_store #(
    .DATA_W(DATA_W), .DEPTH(DEPTH), .PTR_W(PTR_W)
  ) store_i (
    .clk(clk), .strb(strb), .wrIdx(wrIdx), .rdIdx(rdIdx),
    .inData(inData), .outData(outData)
  );

  // A stored head that is not taken stays presented and unchanged
  p_hold_head_r1: assert property (@(posedge clk) disable iff (rst)
    (outVal && !outRdy && count != '0) |=> (outVal && $stable(outData)));

endmodule

// File: tb/rvq_queue_tb_top.sv
module rvq_queue_tb_top;

  localparam int NL = 4;
  localparam int LDEP  [NL] = '{1, 1, 3, 4};
  localparam bit LPIPE [NL] = '{1'b1, 1'b0, 1'b0, 1'b1};
  localparam bit LFLOW [NL] = '{1'b0, 1'b1, 1'b0, 1'b1};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic inVal = 1'b0;
  logic outRdy = 1'b0;
  logic [7:0] inData = '0;

  always #5 clk = ~clk;

  logic       gIR [NL];
  logic       gOV [NL];
  logic [7:0] gOD [NL];
  logic [2:0] gCnt[NL];
  logic [0:0] c0, c1;
  logic [1:0] c2;
  logic [2:0] c3;

  // Lane 0: depth 1, PIPE only (register stage)
  rvq_queue #(.DATA_W(8), .DEPTH(1), .PIPE(1'b1), .FLOW(1'b0)) dut_i (
    .clk(clk), .rst(rst), .inVal(inVal), .inRdy(gIR[0]), .inData(inData),
    .outVal(gOV[0]), .outRdy(outRdy), .outData(gOD[0]), .count(c0));
  // Lane 1: depth 1, FLOW only (ready-breaking stage)
  rvq_queue #(.DATA_W(8), .DEPTH(1), .PIPE(1'b0), .FLOW(1'b1)) dut1_i (
    .clk(clk), .rst(rst), .inVal(inVal), .inRdy(gIR[1]), .inData(inData),
    .outVal(gOV[1]), .outRdy(outRdy), .outData(gOD[1]), .count(c1));
  // Lane 2: depth 3, neither option
  rvq_queue #(.DATA_W(8), .DEPTH(3), .PIPE(1'b0), .FLOW(1'b0)) dut2_i (
    .clk(clk), .rst(rst), .inVal(inVal), .inRdy(gIR[2]), .inData(inData),
    .outVal(gOV[2]), .outRdy(outRdy), .outData(gOD[2]), .count(c2));
  // Lane 3: depth 4, both options
  rvq_queue #(.DATA_W(8), .DEPTH(4), .PIPE(1'b1), .FLOW(1'b1)) dut3_i (
    .clk(clk), .rst(rst), .inVal(inVal), .inRdy(gIR[3]), .inData(inData),
    .outVal(gOV[3]), .outRdy(outRdy), .outData(gOD[3]), .count(c3));

  assign gCnt[0] = {2'b00, c0};
  assign gCnt[1] = {2'b00, c1};
  assign gCnt[2] = {1'b0, c2};
  assign gCnt[3] = c3;

  int nChk = 0;
  int nBad = 0;
  bit done = 0;

  int mq   [NL][4];
  int mHead[NL];
  int mCnt [NL];

  task automatic check(input string tag, input int lane, input int act, input int exp);
    nChk++;
    if (act != exp) begin
      nBad++;
      $display("FAIL %s lane %0d: actual %0d expected %0d at %0t", tag, lane, act, exp, $time);
    end
  endtask

  // Compare one lane with the model, then advance the model across the coming edge
  task automatic stepLane(input int l);
    int c, d;
    bit eIR, eOV, enq, deq;
    int eOD;
    string sfx;
    c = mCnt[l];
    d = LDEP[l];
    sfx = (d == 1) ? " R8" : "";
    eIR = (c < d) || (LPIPE[l] && outRdy);
    eOV = (c > 0) || (LFLOW[l] && inVal);
    eOD = (c > 0) ? mq[l][mHead[l]] : int'(inData);
    check(LPIPE[l] ? {"R3", sfx} : {"R2", sfx}, l, int'(gIR[l]), int'(eIR));
    check((!LFLOW[l] && c == 0) ? {"R9", sfx} : {"R4", sfx}, l, int'(gOV[l]), int'(eOV));
    if (eOV) check((c > 0) ? {"R1", sfx} : {"R5", sfx}, l, int'(gOD[l]), eOD);
    check({"R6", sfx}, l, int'(gCnt[l]), c);
    enq = inVal && eIR;
    deq = eOV && outRdy;
    if (!(c == 0 && LFLOW[l] && deq)) begin
      if (deq) begin
        mHead[l] = (mHead[l] + 1) % d;
        c = c - 1;
      end
      if (enq) begin
        mq[l][(mHead[l] + c) % d] = int'(inData);
        c = c + 1;
      end
    end
    mCnt[l] = c;
  endtask

  task automatic runPhase(input int cycles, input int pVal, input int pRdy);
    for (int k = 0; k < cycles; k++) begin
      @(negedge clk);
      inVal  = ($urandom_range(99) < pVal);
      outRdy = ($urandom_range(99) < pRdy);
      inData = inData + 8'd1;
      #2;
      for (int l = 0; l < NL; l++) stepLane(l);
    end
  endtask

  initial begin
    for (int l = 0; l < NL; l++) begin
      mHead[l] = 0;
      mCnt[l]  = 0;
    end
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    #2;
    // R7: reset state, inVal low
    for (int l = 0; l < NL; l++) begin
      check("R7", l, int'(gCnt[l]), 0);
      check("R7", l, int'(gOV[l]), 0);
      check("R7", l, int'(gIR[l]), 1);
    end
    runPhase(600, 90, 20);   // fill-heavy
    runPhase(600, 20, 90);   // drain-heavy
    runPhase(1500, 50, 50);  // balanced
    runPhase(300, 100, 0);   // stay full
    runPhase(300, 100, 100); // full with constant drain (pipe path)
    runPhase(300, 0, 100);   // empty out
    runPhase(300, 100, 100); // empty with constant traffic (flow path)
    runPhase(1000, 70, 70);
    // Reset mid-traffic: R7
    @(negedge clk);
    rst = 1'b1;
    inVal = 1'b1;
    outRdy = 1'b0;
    @(negedge clk);
    inVal = 1'b0;
    rst = 1'b0;
    #2;
    for (int l = 0; l < NL; l++) begin
      mHead[l] = 0;
      mCnt[l]  = 0;
      check("R7", l, int'(gCnt[l]), 0);
      check("R7", l, int'(gOV[l]), 0);
    end
    runPhase(500, 60, 40);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nChk++;
      nBad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
      $finish;
    end
  end

endmodule